// File: doc/BRIEF.md
# Capacitor Mismatch Calibration Sequencer

This block runs the second calibration pass of a differential SAR converter once the comparator offset pass has finished. Each side of the capacitive DAC has seven thermometer-weighted capacitor groups. Each group's weight should equal the whole binary-weighted array. The sequencer tests one group at a time: it raises that group's bottom plate to reference on one side and raises every binary plate on the opposite side. The leftover differential voltage sets how long the comparator takes to decide. A small residue gives a slow decision, and a large residue gives a fast one.

The analog delay references are replaced by a timer that counts fast clock cycles from the start of each evaluation window. The timer value at the first rising edge of the comparator output is compared against two programmable thresholds, which gives a 2-bit code. All positive-side groups are measured first, in order 0 to 6, and then the negative-side groups in the same order. Each code is stored in a per-side bank.

When the last code is stored, the sequencer raises a done flag. From then on it drives two compensation switches per group, a half-unit and a full-unit switch. Together these give corrections of -0.5, 0, +0.5 or +1 LSB. The codes are static and are applied before normal conversion starts.

Top module: `capmis_cal_seq`

## Requirements
- R1: After reset all plate controls are low, the done flag is low, every stored 2-bit code is 2'b11 and every compensation switch is off.
- R2: A rising edge on the start input, seen while idle or done, begins a run. The run has one cycle with all plates grounded, then positive-side groups 0..6 in order, then negative-side groups 0..6. A start level that stays high, or a new rising edge during a run, neither restarts the run nor changes its order.
- R3: While positive-side group i is evaluated, only bit i of the positive unit-plate vector is high, all negative binary plates are high, and the negative unit plates and positive binary plates are low. The negative pass mirrors this.
- R4: Each evaluation window keeps its plates up for exactly WIN clock cycles. It is followed by one write cycle with every plate grounded.
- R5: Latency L is the window cycle index (0 = first cycle the plates are up) at which the comparator's first rising edge is seen. The code is bit0 = (L >= near threshold) and bit1 = (L >= far threshold), so L below near gives 2'b00, L between near and far gives 2'b01, and L at or above far gives 2'b11.
- R6: If no rising comparator edge occurs inside the window, the code is 2'b11 (smallest mismatch).
- R7: Only the first rising comparator edge in a window counts. Later edges in the same window do not change the code.
- R8: The code of positive (negative) group i is stored in bits [2i+1:2i] of the positive (negative) code output, and other slots keep their values.
- R9: The done flag rises one cycle after the last negative-side write cycle. It stays high with stored codes unchanged until a new run starts. No plate is driven while done is high.
- R10: While done is high each group's switches follow its code, written as {full, half}: 2'b11 -> half on, full off (0 LSB); 2'b01 -> full on, half off (+0.5 LSB); 2'b00 -> both on (+1 LSB); 2'b10 -> both off (-0.5 LSB). While done is low all switches are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timebase of the latency timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| ofs_done_i | input | 1 | End of offset calibration; a rising edge starts a run |
| cmp_out_i | input | 1 | Comparator decision output; its rising edge ends the latency measurement |
| thr_near_i | input | $clog2(WIN+1) | Near threshold in timer cycles (first reference edge) |
| thr_far_i | input | $clog2(WIN+1) | Far threshold in timer cycles (second reference edge) |
| unit_p_o | output | NU | Positive-side thermometer group plates to reference, one bit per group |
| unit_n_o | output | NU | Negative-side thermometer group plates to reference |
| bin_p_o | output | NB | Positive-side binary plates to reference |
| bin_n_o | output | NB | Negative-side binary plates to reference |
| cal_done_o | output | 1 | Calibration finished; codes valid and applied |
| code_p_o | output | 2*NU | Stored positive-side codes, group i in bits [2i+1:2i] |
| code_n_o | output | 2*NU | Stored negative-side codes, group i in bits [2i+1:2i] |
| sw_half_p_o | output | NU | Positive-side half-unit compensation switches |
| sw_full_p_o | output | NU | Positive-side full-unit compensation switches |
| sw_half_n_o | output | NU | Negative-side half-unit compensation switches |
| sw_full_n_o | output | NU | Negative-side full-unit compensation switches |

## Verification
The bench drives comparator edges at exactly the near and far threshold counts and one cycle before each. A design with an off-by-one compare, or a timer that starts one cycle late, would then place a group in the neighbouring region. Windows with no edge at all, including an edge scheduled one cycle past the window, check that a missing decision becomes the smallest-mismatch code rather than a stale or zero code. A second pulse inside the same window would overwrite the code in a design that latches the last edge instead of the first. A start edge raised in the middle of a run would send a restarting design back to group 0, and the bench's order check catches this. Inverted thresholds produce the 2'b10 code, which exposes a switch decoder that never turns both switches off.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GROUND,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } cal_st_e;

    // Code used for "no decision inside the window" and as reset value.
    localparam logic [1:0] CODE_QUIET = 2'b11;

    // Map a stored 2-bit code onto the compensation switches, {full, half}.
    function automatic logic [1:0] code_to_sw(input logic [1:0] code);
        logic [1:0] sw;
        sw[1] = ~code[1];
        sw[0] = ~(code[1] ^ code[0]);
        return sw;
    endfunction

endpackage

// File: rtl/cmc_seq.sv
module cmc_seq
    import cmc_pkg::*;
#(
    parameter int NU  = 7,
    parameter int NB  = 7,
    parameter int WIN = 32,
    localparam int IW  = (NU > 1) ? $clog2(NU) : 1,
    localparam int TMW = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    output cal_st_e        st_o,
    output logic           side_o,
    output logic [IW-1:0]  idx_o,
    output logic [TMW-1:0] tmr_o,
    output logic [NU-1:0]  unit_p_o,
    output logic [NU-1:0]  unit_n_o,
    output logic [NB-1:0]  bin_p_o,
    output logic [NB-1:0]  bin_n_o
);

    typedef struct packed {
        cal_st_e        st;
        logic           side;
        logic [IW-1:0]  idx;
        logic [TMW-1:0] tmr;
        logic           start_prev;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start_rise;

    always_comb begin
        seq_d            = seq_q;
        seq_d.start_prev = start_i;
        start_rise       = start_i && !seq_q.start_prev;
        unique case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_rise) begin
                    seq_d.st   = ST_GROUND;
                    seq_d.side = 1'b0;
                    seq_d.idx  = '0;
                    seq_d.tmr  = '0;
                end
            end
            ST_GROUND: begin
                seq_d.st  = ST_EVAL;
                seq_d.tmr = '0;
            end
            ST_EVAL: begin
                if (seq_q.tmr == TMW'(WIN - 1)) begin
                    seq_d.st = ST_WRITE;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_WRITE: begin
                seq_d.tmr = '0;
                if (seq_q.idx == IW'(NU - 1)) begin
                    if (seq_q.side) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        seq_d.st   = ST_EVAL;
                        seq_d.side = 1'b1;
                        seq_d.idx  = '0;
                    end
                end else begin
                    seq_d.st  = ST_EVAL;
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st         <= ST_IDLE;
            seq_q.side       <= 1'b0;
            seq_q.idx        <= '0;
            seq_q.tmr        <= '0;
            seq_q.start_prev <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    logic eval_p, eval_n;
    assign eval_p = (seq_q.st == ST_EVAL) && !seq_q.side;
    assign eval_n = (seq_q.st == ST_EVAL) &&  seq_q.side;

    for (genvar g = 0; g < NU; g++) begin : g_unit
        assign unit_p_o[g] = eval_p && (seq_q.idx == IW'(g));
        assign unit_n_o[g] = eval_n && (seq_q.idx == IW'(g));
    end

    // The opposite branch's binary array is held at reference as the yardstick.
    assign bin_n_o = {NB{eval_p}};
    assign bin_p_o = {NB{eval_n}};

    assign st_o   = seq_q.st;
    assign side_o = seq_q.side;
    assign idx_o  = seq_q.idx;
    assign tmr_o  = seq_q.tmr;

endmodule

// File: rtl/cmc_delay_quant.sv
module cmc_delay_quant
    import cmc_pkg::*;
#(
    parameter int TMW = 5,
    parameter int TW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           eval_i,
    input  logic [TMW-1:0] tmr_i,
    input  logic           cmp_i,
    input  logic [TW-1:0]  near_i,
    input  logic [TW-1:0]  far_i,
    output logic [1:0]     code_o
);

    typedef struct packed {
        logic       cmp_prev;
        logic       hit;
        logic [1:0] code;
    } qnt_t;

    qnt_t qnt_d, qnt_q;
    logic [TW-1:0] tmr_x;
    logic          edge_seen;

    always_comb begin
        qnt_d          = qnt_q;
        qnt_d.cmp_prev = cmp_i;
        tmr_x          = TW'(tmr_i);
        edge_seen      = cmp_i && !qnt_q.cmp_prev;
        if (!eval_i) begin
            qnt_d.hit  = 1'b0;
            qnt_d.code = CODE_QUIET;
        end else if (!qnt_q.hit && edge_seen) begin
            // Sample both reference thresholds once, on the first decision edge.
            qnt_d.hit     = 1'b1;
            qnt_d.code[0] = (tmr_x >= near_i);
            qnt_d.code[1] = (tmr_x >= far_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qnt_q.cmp_prev <= 1'b0;
            qnt_q.hit      <= 1'b0;
            qnt_q.code     <= CODE_QUIET;
        end else begin
            qnt_q <= qnt_d;
        end
    end

    assign code_o = qnt_q.code;

endmodule

// File: rtl/cmc_code_bank.sv
module cmc_code_bank
    import cmc_pkg::*;
#(
    parameter int NU = 7,
    localparam int IW = (NU > 1) ? $clog2(NU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            side_i,
    input  logic [IW-1:0]   idx_i,
    input  logic [1:0]      code_i,
    input  logic            done_i,
    output logic [2*NU-1:0] code_p_o,
    output logic [2*NU-1:0] code_n_o,
    output logic [NU-1:0]   half_p_o,
    output logic [NU-1:0]   full_p_o,
    output logic [NU-1:0]   half_n_o,
    output logic [NU-1:0]   full_n_o
);

    typedef struct packed {
        logic [NU-1:0][1:0] pos;
        logic [NU-1:0][1:0] neg;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NU; i++) begin
            if (wr_i && (idx_i == IW'(i))) begin
                if (side_i) bank_d.neg[i] = code_i;
                else        bank_d.pos[i] = code_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.pos <= {NU{CODE_QUIET}};
            bank_q.neg <= {NU{CODE_QUIET}};
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar g = 0; g < NU; g++) begin : g_slot
        logic [1:0] sw_p, sw_n;
        assign sw_p = code_to_sw(bank_q.pos[g]);
        assign sw_n = code_to_sw(bank_q.neg[g]);
        assign code_p_o[2*g +: 2] = bank_q.pos[g];
        assign code_n_o[2*g +: 2] = bank_q.neg[g];
        assign full_p_o[g] = done_i && sw_p[1];
        assign half_p_o[g] = done_i && sw_p[0];
        assign full_n_o[g] = done_i && sw_n[1];
        assign half_n_o[g] = done_i && sw_n[0];
    end

endmodule

// File: rtl/capmis_cal_seq.sv
module capmis_cal_seq
    import cmc_pkg::*;
#(
    parameter int NU  = 7,
    parameter int NB  = 7,
    parameter int WIN = 32,
    localparam int TW  = $clog2(WIN + 1),
    localparam int TMW = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int IW  = (NU > 1) ? $clog2(NU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ofs_done_i,
    input  logic            cmp_out_i,
    input  logic [TW-1:0]   thr_near_i,
    input  logic [TW-1:0]   thr_far_i,
    output logic [NU-1:0]   unit_p_o,
    output logic [NU-1:0]   unit_n_o,
    output logic [NB-1:0]   bin_p_o,
    output logic [NB-1:0]   bin_n_o,
    output logic            cal_done_o,
    output logic [2*NU-1:0] code_p_o,
    output logic [2*NU-1:0] code_n_o,
    output logic [NU-1:0]   sw_half_p_o,
    output logic [NU-1:0]   sw_full_p_o,
    output logic [NU-1:0]   sw_half_n_o,
    output logic [NU-1:0]   sw_full_n_o
);

    cal_st_e        st;
    logic           side;
    logic [IW-1:0]  idx;
    logic [TMW-1:0] tmr;
    logic [1:0]     code;
    logic           eval_act, wr_act;

    cmc_seq #(.NU(NU), .NB(NB), .WIN(WIN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (ofs_done_i),
        .st_o     (st),
        .side_o   (side),
        .idx_o    (idx),
        .tmr_o    (tmr),
        .unit_p_o (unit_p_o),
        .unit_n_o (unit_n_o),
        .bin_p_o  (bin_p_o),
        .bin_n_o  (bin_n_o)
    );

    assign eval_act   = (st == ST_EVAL);
    assign wr_act     = (st == ST_WRITE);
    assign cal_done_o = (st == ST_DONE);

    cmc_delay_quant #(.TMW(TMW), .TW(TW)) u_quant (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval_i (eval_act),
        .tmr_i  (tmr),
        .cmp_i  (cmp_out_i),
        .near_i (thr_near_i),
        .far_i  (thr_far_i),
        .code_o (code)
    );

    cmc_code_bank #(.NU(NU)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_act),
        .side_i   (side),
        .idx_i    (idx),
        .code_i   (code),
        .done_i   (cal_done_o),
        .code_p_o (code_p_o),
        .code_n_o (code_n_o),
        .half_p_o (sw_half_p_o),
        .full_p_o (sw_full_p_o),
        .half_n_o (sw_half_n_o),
        .full_n_o (sw_full_n_o)
    );

endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
    parameter int NU = 7,
    parameter int NB = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NU-1:0]   unit_p_o,
    input logic [NU-1:0]   unit_n_o,
    input logic [NB-1:0]   bin_p_o,
    input logic [NB-1:0]   bin_n_o,
    input logic            cal_done_o,
    input logic [2*NU-1:0] code_p_o,
    input logic [2*NU-1:0] code_n_o,
    input logic [NU-1:0]   sw_half_p_o,
    input logic [NU-1:0]   sw_full_p_o,
    input logic [NU-1:0]   sw_half_n_o,
    input logic [NU-1:0]   sw_full_n_o
);

    AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !((|unit_p_o) && (|unit_n_o))); // R3

    AST_POS_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_p_o) |-> ($countones(unit_p_o) == 1 && bin_n_o == '1 && bin_p_o == '0)); // R3

    AST_NEG_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_n_o) |-> ($countones(unit_n_o) == 1 && bin_p_o == '1 && bin_n_o == '0)); // R3

    AST_DONE_PLATES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> (unit_p_o == '0 && unit_n_o == '0 && bin_p_o == '0 && bin_n_o == '0)); // R9

    AST_SWITCHES_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done_o |-> (sw_half_p_o == '0 && sw_full_p_o == '0 &&
                         sw_half_n_o == '0 && sw_full_n_o == '0)); // R10

    AST_CODES_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done_o && $past(cal_done_o)) |-> ($stable(code_p_o) && $stable(code_n_o))); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done_o) |-> $past(unit_n_o[NU-1], 2)); // R2

endmodule

bind capmis_cal_seq cmc_chk #(.NU(NU), .NB(NB)) u_cmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_p_o    (unit_p_o),
    .unit_n_o    (unit_n_o),
    .bin_p_o     (bin_p_o),
    .bin_n_o     (bin_n_o),
    .cal_done_o  (cal_done_o),
    .code_p_o    (code_p_o),
    .code_n_o    (code_n_o),
    .sw_half_p_o (sw_half_p_o),
    .sw_full_p_o (sw_full_p_o),
    .sw_half_n_o (sw_half_n_o),
    .sw_full_n_o (sw_full_n_o)
);

// File: tb/test_capmis_cal_seq.sv
module test_capmis_cal_seq;

    localparam int NU     = 7;
    localparam int NB     = 7;
    localparam int WIN    = 32;
    localparam int TW     = $clog2(WIN + 1);
    localparam int CLK_NS = 10;
    localparam int NONE   = 999;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ofs_done = 1'b0;
    logic            cmp_out = 1'b0;
    logic [TW-1:0]   thr_near = '0;
    logic [TW-1:0]   thr_far = '0;
    logic [NU-1:0]   unit_p, unit_n;
    logic [NB-1:0]   bin_p, bin_n;
    logic            cal_done;
    logic [2*NU-1:0] code_p, code_n;
    logic [NU-1:0]   half_p, full_p, half_n, full_n;

    int n_chk = 0;
    int n_fail = 0;
    int lat_p[NU];
    int lat_n[NU];

    always #(CLK_NS/2) clk = ~clk;

    capmis_cal_seq #(.NU(NU), .NB(NB), .WIN(WIN)) i_capmis_cal_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ofs_done_i  (ofs_done),
        .cmp_out_i   (cmp_out),
        .thr_near_i  (thr_near),
        .thr_far_i   (thr_far),
        .unit_p_o    (unit_p),
        .unit_n_o    (unit_n),
        .bin_p_o     (bin_p),
        .bin_n_o     (bin_n),
        .cal_done_o  (cal_done),
        .code_p_o    (code_p),
        .code_n_o    (code_n),
        .sw_half_p_o (half_p),
        .sw_full_p_o (full_p),
        .sw_half_n_o (half_n),
        .sw_full_n_o (full_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input int lat, input int near, input int far);
        logic [1:0] c;
        if (lat >= WIN) return 2'b11;
        c[0] = (lat >= near);
        c[1] = (lat >= far);
        return c;
    endfunction

    // Returns {full, half} expected for a code.
    function automatic logic [1:0] exp_sw(input logic [1:0] c);
        case (c)
            2'b11:   return 2'b01;
            2'b01:   return 2'b10;
            2'b00:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Evaluate one group: wait for its plates, inject the decision edge, count the window.
    task automatic do_unit(input int side, input int i, input int lat, input bit dbl,
                           output int waitc);
        int cnt;
        logic [NU-1:0] exp_u;
        waitc = 0;
        while (unit_p == '0 && unit_n == '0) begin
            @(negedge clk);
            waitc++;
        end
        exp_u = NU'(1) << i;
        if (side == 0) begin
            check(unit_p == exp_u, "R2", $sformatf("pos group %0d order", i), unit_p, exp_u);
            check(unit_n == '0 && bin_p == '0 && bin_n == '1, "R3",
                  $sformatf("pos group %0d opposite plates", i), {unit_n, bin_p, bin_n},
                  {NU'(0), NB'(0), {NB{1'b1}}});
        end else begin
            check(unit_n == exp_u, "R2", $sformatf("neg group %0d order", i), unit_n, exp_u);
            check(unit_p == '0 && bin_n == '0 && bin_p == '1, "R3",
                  $sformatf("neg group %0d opposite plates", i), {unit_p, bin_n, bin_p},
                  {NU'(0), NB'(0), {NB{1'b1}}});
        end
        check(cal_done == 1'b0, "R9", "done low during run", cal_done, 0);
        cnt = 0;
        if (lat == 0) cmp_out = 1'b1;
        forever begin
            @(negedge clk);
            cnt++;
            if (unit_p == '0 && unit_n == '0) break;
            if (cnt == lat) cmp_out = 1'b1;
            if (dbl && cnt == lat + 2) cmp_out = 1'b0;
            if (dbl && cnt == lat + 4) cmp_out = 1'b1;
        end
        check(cnt == WIN, "R4", $sformatf("window length side %0d group %0d", side, i), cnt, WIN);
        check(bin_p == '0 && bin_n == '0, "R4", "write cycle grounds binary plates",
              {bin_p, bin_n}, 0);
        cmp_out = 1'b0;
    endtask

    task automatic run_cal(input int near, input int far, input bit dbl,
                           input bit retrig, input bit hold);
        int waitc;
        logic [1:0] ec;
        logic [1:0] es;
        thr_near = TW'(near);
        thr_far  = TW'(far);
        ofs_done = 1'b1;
        @(negedge clk);
        check(unit_p == '0 && unit_n == '0 && bin_p == '0 && bin_n == '0, "R2",
              "ground cycle before first group", {unit_p, unit_n}, 0);
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < NU; i++) begin
                do_unit(s, i, (s == 0) ? lat_p[i] : lat_n[i], dbl, waitc);
                check(waitc == 1, "R2", $sformatf("gap before side %0d group %0d", s, i),
                      waitc, 1);
                if (s == 0 && i == 0 && !hold) ofs_done = 1'b0;
                if (retrig && s == 0 && i == 2) ofs_done = 1'b1;
                if (retrig && s == 0 && i == 4) ofs_done = 1'b0;
            end
        end
        @(negedge clk);
        check(cal_done == 1'b1, "R9", "done one cycle after last write", cal_done, 1);
        for (int i = 0; i < NU; i++) begin
            ec = exp_code(lat_p[i], near, far);
            check(code_p[2*i +: 2] == ec, "R5", $sformatf("pos code group %0d (R6 R8)", i),
                  code_p[2*i +: 2], ec);
            es = exp_sw(ec);
            check({full_p[i], half_p[i]} == es, "R10", $sformatf("pos switches group %0d", i),
                  {full_p[i], half_p[i]}, es);
            ec = exp_code(lat_n[i], near, far);
            check(code_n[2*i +: 2] == ec, "R5", $sformatf("neg code group %0d (R6 R8)", i),
                  code_n[2*i +: 2], ec);
            es = exp_sw(ec);
            check({full_n[i], half_n[i]} == es, "R10", $sformatf("neg switches group %0d", i),
                  {full_n[i], half_n[i]}, es);
        end
        begin
            logic [2*NU-1:0] sp, sn;
            sp = code_p;
            sn = code_n;
            repeat (4) @(negedge clk);
            check(cal_done == 1'b1 && code_p == sp && code_n == sn, "R9",
                  "done and codes hold (held start does not restart R2)", cal_done, 1);
            check(unit_p == '0 && unit_n == '0, "R9", "no plates while done",
                  {unit_p, unit_n}, 0);
        end
        ofs_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1205));
        repeat (3) @(negedge clk);
        check(unit_p == '0 && unit_n == '0 && bin_p == '0 && bin_n == '0, "R1",
              "plates in reset", {unit_p, unit_n, bin_p, bin_n}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cal_done == 1'b0, "R1", "done after reset", cal_done, 0);
        check(code_p == '1 && code_n == '1, "R1", "codes after reset",
              {code_p, code_n}, {(4*NU){1'b1}});
        check(half_p == '0 && full_p == '0 && half_n == '0 && full_n == '0, "R1",
              "switches after reset", {half_p, full_p, half_n, full_n}, 0);
        check(unit_p == '0 && unit_n == '0, "R1", "idle without start",
              {unit_p, unit_n}, 0);

        // R6: no decision anywhere.
        for (int i = 0; i < NU; i++) begin lat_p[i] = NONE; lat_n[i] = NONE; end
        run_cal(8, 16, 1'b0, 1'b0, 1'b0);

        // R5: threshold boundaries; WIN itself is outside the window (R6).
        lat_p = '{0, 7, 8, 15, 16, WIN-1, NONE};
        lat_n = '{WIN-1, 16, 15, 8, 7, 0, WIN};
        run_cal(8, 16, 1'b0, 1'b0, 1'b0);

        // R7: a second edge later in the window must not change the code.
        for (int i = 0; i < NU; i++) begin
            lat_p[i] = int'($urandom_range(0, 2));
            lat_n[i] = int'($urandom_range(0, 2));
        end
        run_cal(3, 6, 1'b1, 1'b0, 1'b0);

        // R2: start edge during a run is ignored.
        for (int i = 0; i < NU; i++) begin
            lat_p[i] = int'($urandom_range(0, WIN + 3));
            lat_n[i] = int'($urandom_range(0, WIN + 3));
        end
        run_cal(10, 20, 1'b0, 1'b1, 1'b0);

        // R2: start held high across the whole run.
        run_cal(5, 25, 1'b0, 1'b0, 1'b1);

        // R10: inverted thresholds give code 2'b10 (both switches off).
        lat_p = '{10, 2, 25, 6, 19, NONE, 5};
        lat_n = '{12, 0, 20, 4, 30, 9, 15};
        run_cal(20, 5, 1'b0, 1'b0, 1'b0);

        // Random runs.
        for (int r = 0; r < 16; r++) begin
            int nr, fr;
            nr = int'($urandom_range(1, WIN / 2));
            fr = int'($urandom_range(nr + 1, WIN));
            for (int i = 0; i < NU; i++) begin
                lat_p[i] = int'($urandom_range(0, WIN + 4));
                lat_n[i] = int'($urandom_range(0, WIN + 4));
            end
            run_cal(nr, fr, 1'b0, 1'b0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule